// File: doc/BRIEF.md
# Serial Receiver Idle Time-out Detector

This block watches the idle time that follows each character on a serial receive line and tells the driver when a variable-length frame has ended. It works from a few inputs. A per-bit-period tick clocks a down-counter. A strobe from the deserialiser reports each completed character. A 16-bit programmed delay sets the count. A command arms the detector. When the count runs out after the last character, a sticky time-out flag rises. The interrupt line is that flag gated by an enable.

A programmed delay of zero turns the detector off. The arm command clears the flag and holds the counter still until the next character arrives, so a line that is idle before that character never reports a time-out. Character deserialisation, baud generation and the register interface are outside this block.

Top module: `rx_idle_timeout`

## Requirements
- R1: While `toValue` is 0 the detector is disabled. `timeoutFlag` reads 0 in the same cycle that 0 is applied, and it stays 0 for any pattern of characters and ticks.
- R2: After reset, `timeoutFlag` and `irqOut` are 0. The counter waits for a first character, so ticks alone raise no time-out.
- R3: A `charDone` pulse loads the counter with `toValue` = N. `timeoutFlag` rises in the cycle after the N-th subsequent `bitTick` cycle. Cycles without `bitTick` do not count.
- R4: The flag is sticky. Further ticks and later characters leave it at 1. The counter stops at zero and does not wrap.
- R5: A `startCmd` pulse clears `timeoutFlag` by the next cycle and freezes the counter. Ticks that follow it raise no time-out until a character arrives.
- R6: The first character after `startCmd` restarts counting from the full programmed value. If `startCmd` and `charDone` come in the same cycle, the flag is cleared and counting starts.
- R7: If `charDone` and the tick that would reach zero come in the same cycle, the reload wins and no time-out is flagged.
- R8: A change of `toValue` to another nonzero value during counting affects only the next reload. The count in progress finishes with the old value.
- R9: `irqOut` equals `timeoutFlag` AND `irqEnable`. It is level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit period |
| charDone | input | 1 | One-cycle pulse per received character |
| toValue | input | 16 | Programmed idle delay in bit periods, 0 disables |
| startCmd | input | 1 | Arm command: clear flag, freeze until next character |
| irqEnable | input | 1 | Interrupt enable |
| timeoutFlag | output | 1 | Sticky idle time-out status |
| irqOut | output | 1 | Level interrupt request |

## Verification
All inputs are sampled at a clock edge, and the counter and flag registers update at that same edge. A reload, a tick, an arm command or the terminal decrement is therefore visible at `timeoutFlag` one cycle after the cycle that applied it. The one exception is masking by a zero `toValue`, which acts within the same cycle. The bench drives each stimulus at the falling edge and samples just after the following rising edge. For the zero-value masking it samples shortly after the drive, before any edge. Every expected flag value comes from counting ticks since the last reload in the bench's own vector table and directed steps.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic zero;     // clear counter (detector disabled)
    logic load;     // reload counter from programmed value
    logic dec;      // decrement counter by one
    logic setFlag;  // terminal count reached
    logic clrFlag;  // clear sticky flag
  } ctlStrobes_t;
endpackage

// File: rtl/rx_idle_timeout_ctl.sv
module rx_idle_timeout_ctl
  import rx_idle_timeout_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        charDone,
  input  logic        startCmd,
  input  logic        valNz,
  input  logic        cntZero,
  input  logic        cntOne,
  output ctlStrobes_t st
);
  logic running;

  always_comb begin
    st.zero    = !valNz;
    st.load    = valNz && charDone;
    st.dec     = valNz && !charDone && !startCmd && running && bitTick && !cntZero;
    st.setFlag = st.dec && cntOne;
    st.clrFlag = !valNz || startCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              running <= 1'b0;
    else if (!valNz)        running <= 1'b0;
    else if (charDone)      running <= 1'b1;
    else if (startCmd)      running <= 1'b0;
  end

  // R5: a frozen counter is never decremented before a character arrives
  p_frozen_no_dec_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !charDone) |=> !st.dec || charDone);

  // R7: a reload suppresses the terminal-count flag
  p_reload_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    charDone |-> !st.setFlag);
endmodule

// File: rtl/rx_idle_timeout_dp.sv
module rx_idle_timeout_dp
  import rx_idle_timeout_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      st,
  input  logic [CNT_W-1:0] loadVal,
  output logic             cntZero,
  output logic             cntOne,
  output logic             flagReg
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt;

  assign cntZero = (cnt == '0);
  assign cntOne  = (cnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (st.zero) cnt <= '0;
    else if (st.load) cnt <= loadVal;
    else if (st.dec)  cnt <= cnt - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flagReg <= 1'b0;
    else if (st.clrFlag) flagReg <= 1'b0;
    else if (st.setFlag) flagReg <= 1'b1;
  end

  // R4: counter at zero never wraps without a reload
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !st.load) |=> cntZero);

  // R3: flag only rises from a count of one
  p_flag_from_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagReg) |-> $past(cntOne));

  // R5: clearing drops the flag on the next cycle
  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.clrFlag |=> !flagReg);
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rx_idle_timeout_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             charDone,
  input  logic [CNT_W-1:0] toValue,
  input  logic             startCmd,
  input  logic             irqEnable,
  output logic             timeoutFlag,
  output logic             irqOut
);
  ctlStrobes_t st;
  logic valNz, cntZero, cntOne, flagReg;

  assign valNz = (toValue != '0);

  rx_idle_timeout_ctl u_ctl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .charDone(charDone),
    .startCmd(startCmd), .valNz(valNz), .cntZero(cntZero), .cntOne(cntOne),
    .st(st)
  );

  rx_idle_timeout_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .loadVal(toValue),
    .cntZero(cntZero), .cntOne(cntOne), .flagReg(flagReg)
  );

  // R1: a zero delay masks the flag at once
  assign timeoutFlag = flagReg && valNz;
  // R9: level interrupt
  assign irqOut = timeoutFlag && irqEnable;

  // R9: no interrupt without the flag and the enable
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (timeoutFlag && irqEnable));

  // R1: disabled detector never shows the flag
  p_zero_disables_r1: assert property (@(posedge clk) disable iff (!rstN)
    !valNz |-> !timeoutFlag);
endmodule

// File: tb/tb_rx_idle_timeout.sv
module tb_rx_idle_timeout;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, charDone = 1'b0, startCmd = 1'b0, irqEnable = 1'b0;
  logic [15:0] toValue = 16'd0;
  logic timeoutFlag, irqOut;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rx_idle_timeout dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .charDone(charDone),
    .toValue(toValue), .startCmd(startCmd), .irqEnable(irqEnable),
    .timeoutFlag(timeoutFlag), .irqOut(irqOut)
  );

  // vector: {charDone, bitTick, startCmd, expected flag after the edge}, delay = 3
  localparam int NVEC = 23;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0100, // R2 frozen after reset
    4'b1000, // R3 load 3
    4'b0100, 4'b0100, 4'b0101, // R3 third tick flags
    4'b0101, // R4 sticky
    4'b1001, // R4 char keeps flag
    4'b0010, // R5 start clears
    4'b0100, 4'b0100, 4'b0100, 4'b0100, // R5 frozen
    4'b1000, // R6 restart from 3
    4'b0100, 4'b0100,
    4'b1100, // R7 reload wins at terminal tick
    4'b0100, 4'b0100, 4'b0101, // R7 full count again
    4'b1010, // R6 start+char together
    4'b0100, 4'b0100, 4'b0101
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic t, input logic s);
    @(negedge clk);
    charDone = c; bitTick = t; startCmd = s;
    @(posedge clk);
    #1;
    charDone = 1'b0; bitTick = 1'b0; startCmd = 1'b0;
  endtask

  initial begin
    irqEnable = 1'b1;
    toValue = 16'd3;
    repeat (3) @(posedge clk);
    #1;
    chk(timeoutFlag == 1'b0 && irqOut == 1'b0, "R2 reset", int'(timeoutFlag), 0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][3], VEC[i][2], VEC[i][1]);
      chk(timeoutFlag == VEC[i][0], $sformatf("R3/R4/R5/R6/R7 vector %0d", i),
          int'(timeoutFlag), int'(VEC[i][0]));
      chk(irqOut == VEC[i][0], $sformatf("R9 irq vector %0d", i), int'(irqOut), int'(VEC[i][0]));
    end

    // R9: enable low masks interrupt while flag stays set
    @(negedge clk) irqEnable = 1'b0;
    #1;
    chk(irqOut == 1'b0 && timeoutFlag == 1'b1, "R9 enable low", int'(irqOut), 0);
    @(negedge clk) irqEnable = 1'b1;
    #1;
    chk(irqOut == 1'b1, "R9 enable high", int'(irqOut), 1);

    // R1: zero masks at once, then stays disabled
    @(negedge clk) toValue = 16'd0;
    #1;
    chk(timeoutFlag == 1'b0, "R1 immediate mask", int'(timeoutFlag), 0);
    cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0);
    chk(timeoutFlag == 1'b0, "R1 disabled ticks", int'(timeoutFlag), 0);
    @(negedge clk) toValue = 16'd2;
    #1;
    chk(timeoutFlag == 1'b0, "R1 flag cleared by zero", int'(timeoutFlag), 0);
    cyc(1'b0, 1'b1, 1'b0); cyc(1'b0, 1'b1, 1'b0); cyc(1'b0, 1'b1, 1'b0);
    chk(timeoutFlag == 1'b0, "R1 re-enable waits for char", int'(timeoutFlag), 0);

    // R3: value 1 boundary, idle cycles do not count
    @(negedge clk) toValue = 16'd1;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0);
    chk(timeoutFlag == 1'b0, "R3 no tick no count", int'(timeoutFlag), 0);
    cyc(1'b0, 1'b1, 1'b0);
    chk(timeoutFlag == 1'b1, "R3 value one", int'(timeoutFlag), 1);

    // R8: value change mid-count waits for the next reload
    cyc(1'b0, 1'b0, 1'b1);
    @(negedge clk) toValue = 16'd3;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    @(negedge clk) toValue = 16'd5;
    cyc(1'b0, 1'b1, 1'b0);
    chk(timeoutFlag == 1'b0, "R8 mid count", int'(timeoutFlag), 0);
    cyc(1'b0, 1'b1, 1'b0);
    chk(timeoutFlag == 1'b1, "R8 old value finishes", int'(timeoutFlag), 1);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0);
    chk(timeoutFlag == 1'b0, "R8 new value four ticks", int'(timeoutFlag), 0);
    cyc(1'b0, 1'b1, 1'b0);
    chk(timeoutFlag == 1'b1, "R8 new value fifth tick", int'(timeoutFlag), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule